// File: doc/BRIEF.md
# Dual Interval Timer with Overflow Status

This block holds two 8-bit up-counting interval timers. A host reaches it through a byte-wide port with two locations. Location 0 takes a register index. Location 1 takes the value for that register. A read of location 0 returns a status byte. Two internal tick enables are derived from the system clock by a prescaler. The fast tick comes every 80 µs. The slow tick comes every 320 µs, four fast ticks. Timer A runs on the fast tick and timer B runs on the slow tick.

A timer counts up from a preload value that the host writes. It overflows when it passes 0xFF, then reloads and keeps counting. When a timer overflows while its mask bit is clear, it latches an overflow flag. The status byte reports both flags and an OR summary. The interrupt output follows that summary. A single clear command drops every flag and leaves the timer settings as they were.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset the status byte reads 0x00 and irq_o is low. Both timers are stopped and unmasked.
- R2: A register write is two bus writes: the index to location 0 (addr_i=0), then the value to location 1 (addr_i=1). Index 0x02 is the timer A preload, 0x03 is the timer B preload and 0x04 is control. Writes to any other index change nothing.
- R3: Control value bits: bit 0 starts timer A, bit 1 starts timer B, bit 6 masks timer A, bit 5 masks timer B. A control write with bit 7 clear loads all four bits.
- R4: A running timer with preload P overflows after 256−P ticks, then reloads P and continues. Consecutive overflows are exactly (256−P) ticks apart.
- R5: The fast tick occurs every CLK_HZ/12500 clock cycles (80 µs). The slow tick occurs every fourth fast tick (320 µs).
- R6: While a timer's start bit is 0, its counter holds the preload value. A restart therefore takes a full 256−P ticks to its first overflow.
- R7: An overflow sets the timer's flag only when its mask bit is 0. Setting the mask later does not clear a flag that is already set.
- R8: Reading location 0 gives {summary, flag A, flag B, 5'b00000} in bits 7, 6, 5 and 4..0. Reading location 1 gives 0x00.
- R9: irq_o equals the summary bit, which is the OR of the two flags. irq_o rises one cycle after the tick on which an unmasked overflow occurs.
- R10: A control write with bit 7 set clears both flags and leaves the start and mask bits unchanged. The bit is not stored. An overflow in the same cycle as the clear still sets its flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe, one byte per cycle |
| addr_i | input | 1 | Location select: 0 index/status, 1 data |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected location |
| irq_o | output | 1 | Interrupt, high while any flag is set |

## Verification
The bench measures the interval between consecutive overflows exactly, on both timers. A prescaler or reload off by one cycle shifts that interval. It stops a timer partway through a period and restarts it. A counter that does not return to its preload on stop then overflows early. The bench runs a masked timer long enough to overflow many times, which catches a flag that ignores its mask. After a clear, it waits for a running timer to raise its flag again. A clear that also wiped the start bits leaves the status stuck at zero.

// File: rtl/dit_pkg.sv
package dit_pkg;
  localparam int NCH = 2;
  localparam logic [7:0] IDX_PRE_A = 8'h02;
  localparam logic [7:0] IDX_PRE_B = 8'h03;
  localparam logic [7:0] IDX_CTRL  = 8'h04;
  localparam int CB_CLEAR  = 7;
  localparam int CB_MASK_A = 6;
  localparam int CB_MASK_B = 5;
  localparam int CB_RUN_B  = 1;
  localparam int CB_RUN_A  = 0;

  typedef struct packed {
    logic [NCH-1:0] mask;
    logic [NCH-1:0] run;
  } ctrl_t;
endpackage

// File: rtl/dit_tick_gen.sv
module dit_tick_gen #(
  parameter int CLK_HZ     = 50_000_000,
  parameter int SLOW_RATIO = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic fast_tick_o,
  output logic slow_tick_o
);
  localparam int FAST_DIV = (CLK_HZ / 12500 < 1) ? 1 : CLK_HZ / 12500;
  localparam int PW = $clog2(FAST_DIV) + 1;
  localparam int SW = $clog2(SLOW_RATIO) + 1;

  logic [PW-1:0] pre_q;
  logic [SW-1:0] sub_q;

  assign fast_tick_o = (pre_q == PW'(FAST_DIV - 1));
  assign slow_tick_o = fast_tick_o && (sub_q == SW'(SLOW_RATIO - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      sub_q <= '0;
    end else begin
      pre_q <= fast_tick_o ? '0 : pre_q + 1'b1;
      if (fast_tick_o) sub_q <= slow_tick_o ? '0 : sub_q + 1'b1;
    end
  end

  AST_SLOW_ON_FAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slow_tick_o |-> fast_tick_o); // R5
  AST_FAST_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fast_tick_o && FAST_DIV > 1) |=> !fast_tick_o); // R5
endmodule

// File: rtl/dit_channel.sv
module dit_channel #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         run_i,
  input  logic [W-1:0] preload_i,
  output logic         ovf_o
);
  logic [W-1:0] cnt_q;

  assign ovf_o = run_i && tick_i && (cnt_q == {W{1'b1}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || ovf_o)  cnt_q <= preload_i;
    else if (tick_i)           cnt_q <= cnt_q + 1'b1;
  end

  AST_HOLD_PRELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == $past(preload_i)); // R6
  AST_WRAP_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> cnt_q == $past(preload_i)); // R4
  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_i) |=> cnt_q == $past(cnt_q) || $past(!run_i)); // R4
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import dit_pkg::*;
#(
  parameter int CLK_HZ     = 50_000_000,
  parameter int SLOW_RATIO = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       irq_o
);
  logic [7:0]     idx_q;
  logic [7:0]     pre_q [NCH];
  ctrl_t          ctrl_q;
  logic [NCH-1:0] flag_q;
  logic [NCH-1:0] ovf;
  logic [NCH-1:0] tick;
  logic           data_wr, ctrl_wr, clr_cmd;

  dit_tick_gen #(.CLK_HZ(CLK_HZ), .SLOW_RATIO(SLOW_RATIO)) u_ticks (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .fast_tick_o(tick[0]), .slow_tick_o(tick[1])
  );

  assign data_wr = wr_i && addr_i;
  assign ctrl_wr = data_wr && (idx_q == IDX_CTRL);
  assign clr_cmd = ctrl_wr && wdata_i[CB_CLEAR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      pre_q  <= '{default: '0};
      ctrl_q <= '0;
    end else begin
      if (wr_i && !addr_i) idx_q <= wdata_i;
      if (data_wr && idx_q == IDX_PRE_A) pre_q[0] <= wdata_i;
      if (data_wr && idx_q == IDX_PRE_B) pre_q[1] <= wdata_i;
      if (ctrl_wr && !wdata_i[CB_CLEAR]) begin
        ctrl_q.mask <= {wdata_i[CB_MASK_B], wdata_i[CB_MASK_A]};
        ctrl_q.run  <= {wdata_i[CB_RUN_B],  wdata_i[CB_RUN_A]};
      end
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dit_channel #(.W(8)) u_ch (
      .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick[i]),
      .run_i(ctrl_q.run[i]), .preload_i(pre_q[i]), .ovf_o(ovf[i])
    );

    // set wins over a same-cycle clear so no overflow is lost
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          flag_q[i] <= 1'b0;
      else if (ovf[i] && !ctrl_q.mask[i])   flag_q[i] <= 1'b1;
      else if (clr_cmd)                     flag_q[i] <= 1'b0;
    end

    AST_MASK_BLOCKS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl_q.mask[i] && !flag_q[i]) |=> !flag_q[i]); // R7
    AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[i] && !clr_cmd) |=> flag_q[i]); // R7
  end

  assign irq_o   = |flag_q;
  assign rdata_o = addr_i ? 8'h00 : {irq_o, flag_q[0], flag_q[1], 5'b00000};

  AST_CLEAR_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_cmd && !(|ovf)) |=> !irq_o); // R10
  AST_CLEAR_KEEPS_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_cmd |=> $stable(ctrl_q)); // R10
  AST_IRQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|(ovf & ~ctrl_q.mask))); // R9
endmodule

// File: tb/dual_interval_timer_tb.sv
module dual_interval_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 100_000;   // 8 cycles per fast tick
  localparam int FDIV       = CLK_HZ / 12500;

  logic       clk = 0;
  logic       rst_ni = 0;
  logic       wr_i = 0;
  logic       addr_i = 0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       irq_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  dual_interval_timer #(.CLK_HZ(CLK_HZ)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_rng(string req, int act, int lo, int hi);
    total++;
    if (act < lo || act > hi) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  // called at a negedge; returns at a negedge two cycles later
  task automatic reg_wr(logic [7:0] idx, logic [7:0] val);
    wr_i = 1; addr_i = 0; wdata_i = idx;
    @(negedge clk);
    addr_i = 1; wdata_i = val;
    @(negedge clk);
    wr_i = 0; addr_i = 0;
  endtask

  task automatic status(output int s);
    addr_i = 0; #1; s = rdata_o;
  endtask

  task automatic wait_irq(int max, output int n);
    n = 0;
    while (!irq_o && n < max) begin @(negedge clk); n++; end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    int s;
    status(s);
    chk("R1 status after reset", s, 8'h00);
    chk("R1 irq after reset", irq_o, 0);
    addr_i = 1; #1;
    chk("R8 read of location 1", rdata_o, 8'h00);
    addr_i = 0;
  endtask

  task automatic t_single_fast;
    int s, n;
    reg_wr(8'h02, 8'hFF);
    reg_wr(8'h04, 8'h21);          // timer A run, timer B masked
    wait_irq(40, n);
    status(s);
    chk("R8 A-only status", s, 8'hC0);
    chk("R9 irq equals summary", irq_o, 1);
    reg_wr(8'h04, 8'h60);          // stop both, mask both
    idle(3);
    status(s);
    chk("R7 flag survives later mask", s, 8'hC0);
    reg_wr(8'h04, 8'h80);
    status(s);
    chk("R10 clear drops flags", s, 8'h00);
    chk("R9 irq low after clear", irq_o, 0);
  endtask

  task automatic t_period_fast;
    int s, n;
    reg_wr(8'h02, 8'hF0);
    reg_wr(8'h04, 8'h21);
    wait_irq(400, n);
    chk("R4 first A overflow seen", irq_o, 1);
    reg_wr(8'h04, 8'h80);          // clear, run bits must persist
    status(s);
    chk("R10 clear while running", s, 8'h00);
    wait_irq(400, n);
    chk("R10 run kept after clear", irq_o, 1);
    chk("R4 R5 A period 16 ticks", n + 2, 16 * FDIV);
    reg_wr(8'h04, 8'h00);
    reg_wr(8'h04, 8'h80);
  endtask

  task automatic t_period_slow;
    int s, n;
    reg_wr(8'h03, 8'hFE);
    reg_wr(8'h04, 8'h42);          // timer B run, timer A masked
    wait_irq(400, n);
    status(s);
    chk("R8 B-only status", s, 8'hA0);
    reg_wr(8'h04, 8'h80);
    wait_irq(400, n);
    chk("R4 R5 B period 2 slow ticks", n + 2, 2 * 4 * FDIV);
    reg_wr(8'h04, 8'h00);
    reg_wr(8'h04, 8'h80);
  endtask

  task automatic t_both;
    int s;
    reg_wr(8'h02, 8'hFF);
    reg_wr(8'h03, 8'hFF);
    reg_wr(8'h04, 8'h03);
    idle(6 * FDIV);
    status(s);
    chk("R8 both flags", s, 8'hE0);
    reg_wr(8'h04, 8'h00);
    reg_wr(8'h04, 8'h80);
    status(s);
    chk("R10 clear both flags", s, 8'h00);
  endtask

  task automatic t_masked;
    int s, n;
    reg_wr(8'h02, 8'hFF);
    reg_wr(8'h03, 8'hFF);
    reg_wr(8'h04, 8'h63);          // both run, both masked
    idle(20 * FDIV);
    status(s);
    chk("R7 masked overflows ignored", s, 8'h00);
    reg_wr(8'h04, 8'h03);          // unmask
    wait_irq(40, n);
    chk("R3 unmask lets flag set", irq_o, 1);
    reg_wr(8'h04, 8'h00);
    reg_wr(8'h04, 8'h80);
  endtask

  task automatic t_hold;
    int s, n;
    reg_wr(8'h02, 8'hFC);
    reg_wr(8'h04, 8'h01);
    idle(2 * FDIV + 2);            // two or three ticks in
    reg_wr(8'h04, 8'h00);
    idle(10 * FDIV);
    status(s);
    chk("R3 stopped timer raises nothing", s, 8'h00);
    reg_wr(8'h04, 8'h01);
    wait_irq(200, n);
    chk_rng("R6 restart takes full period", n, 3 * FDIV + 1, 4 * FDIV);
    reg_wr(8'h04, 8'h00);
    reg_wr(8'h04, 8'h80);
  endtask

  task automatic t_bad_index;
    int s;
    reg_wr(8'h02, 8'hFF);
    reg_wr(8'h05, 8'h03);
    reg_wr(8'h07, 8'h03);
    reg_wr(8'h00, 8'h03);
    idle(10 * FDIV);
    status(s);
    chk("R2 unknown indices ignored", s, 8'h00);
    chk("R2 irq stays low", irq_o, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_ni = 1;
    idle(1);
    t_reset;
    t_single_fast;
    t_period_fast;
    t_period_slow;
    t_both;
    t_masked;
    t_hold;
    t_bad_index;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule